// File: doc/BRIEF.md
# Instruction Operand Fetch Sequencer

This block collects the operands of one instruction on behalf of an execution unit. The execution unit hands it a packed operand pattern, the program counter of the first word after the opcode, and the current A and B accumulator values, then pulses `start`. The sequencer walks the pattern one 4-bit kind code at a time. Each operand comes from the accumulators, from the inline word at the program counter, or from a constant reached through an address word that may be indirect. The results land in operand slots. The slots are read back through an index port.

Memory is reached through a word read port with one request in flight. `mem_req_valid` and `mem_req_addr` stay asserted and stable until the memory raises `mem_req_ready`, and only that cycle counts as the handshake. The memory answers some cycles later with a one-cycle `mem_rsp_valid` pulse. The sequencer always accepts a response while it waits, so the response path has no back-pressure. An address word uses bit 15 as an indirect flag and bits 14..0 as the address. When a chain needs a fourth indirection while an interrupt is pending, the sequencer gives up and reports an abort, so the instruction can be retried later.

Top module: `opf_seq`

## Requirements
- R1: Operands are taken in order from the low 4-bit field of `pattern` upward. Kind code 0 ends the run with a `done` pulse, and `op_count` reports how many operands were produced before it.
- R2: Register kinds. Code 1 stores A in word 0. Codes 2 and 3 store A in word 0 and B in word 1. None of these kinds reads memory.
- R3: Inline kinds. Code 4 stores the word at PC. Code 5 stores PC itself. Code 6 stores the address that the word at PC resolves to.
- R4: Codes 7, 8, 9, 10 and 11 resolve the word at PC to an address, then store 1, 2, 3, 4 and 5 consecutive words from it. The word at the lowest address goes into word 0.
- R5: Consecutive operand addresses and the program counter wrap from 0x7FFF to 0x0000.
- R6: Codes 4 to 11 each advance `pc_out` by one after their operand. Codes 1 to 3 leave it unchanged.
- R7: While resolving, an address word with bit 15 set is followed to the location in its bits 14..0. A word with bit 15 clear ends the chain.
- R8: If an address word with bit 15 set arrives after three indirections have already been followed and `irq_pending` is high, the run stops with an `abort` pulse and no `done`. Without the interrupt, the chain continues.
- R9: Codes 12 to 15 stop the run with an `error` pulse. `op_count` then holds the number of operands completed before the bad code.
- R10: A pattern holds at most four operands. After the fourth, the run ends with `done` and `op_count` = 4, even if no code 0 was seen.
- R11: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid in the next cycle with the same address. No request is issued while idle.
- R12: Every run ends with exactly one one-cycle pulse of `done`, `abort` or `error`, and `busy` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; ignored while busy |
| pattern | input | 16 | Four 4-bit kind codes, first operand in bits 3..0 |
| pc_in | input | 15 | Address of the first inline word |
| a_reg | input | 16 | Accumulator A |
| b_reg | input | 16 | Accumulator B |
| irq_pending | input | 1 | An interrupt is waiting |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 15 | Read address |
| mem_rsp_valid | input | 1 | Read data valid (one cycle) |
| mem_rsp_data | input | 16 | Read data |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Normal completion pulse |
| abort | output | 1 | Interrupt abort pulse |
| error | output | 1 | Bad kind code pulse |
| op_count | output | 3 | Operands produced in the last run |
| pc_out | output | 15 | Program counter after the inline words consumed |
| rd_slot | input | 2 | Operand slot to read |
| rd_word | input | 3 | Word within the slot (0..4) |
| rd_data | output | 16 | Selected slot word |

## Verification
A stale pattern shift register or operand index shows up as operands in the wrong slots or as a wrong `op_count`, visible as soon as the run's end pulse appears. A word counter or address register that is off by one shows up as a wrong or shifted constant word, or as a missing wrap at 0x7FFF, in the slot readback of that same run. A miscounted indirection depth shows up as an `abort` in place of `done`, or the reverse, within a few cycles of the fourth address word. A request that drops or moves during back-pressure shows up on the memory port in the very next cycle.

// File: rtl/opf_pkg.sv
package opf_pkg;
  localparam int KIND_W = 4;

  localparam logic [KIND_W-1:0] K_END  = 4'd0;
  localparam logic [KIND_W-1:0] K_RA   = 4'd1;
  localparam logic [KIND_W-1:0] K_RAB  = 4'd2;
  localparam logic [KIND_W-1:0] K_RFAB = 4'd3;
  localparam logic [KIND_W-1:0] K_IVAL = 4'd4;
  localparam logic [KIND_W-1:0] K_IPTR = 4'd5;
  localparam logic [KIND_W-1:0] K_IADR = 4'd6;
  localparam logic [KIND_W-1:0] K_C1   = 4'd7;
  localparam logic [KIND_W-1:0] K_C5   = 4'd11;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DECODE, ST_RD_REQ, ST_RD_WAIT, ST_NEXT
  } opf_state_t;
endpackage

// File: rtl/opf_kind_decode.sv
module opf_kind_decode #(
  parameter int WIDX_W = 3
) (
  input  logic [opf_pkg::KIND_W-1:0] code,
  output logic                       is_end,
  output logic                       legal,
  output logic                       is_reg,
  output logic                       reg_pair,
  output logic                       is_ival,
  output logic                       is_ptr,
  output logic                       store_addr,
  output logic                       adv_pc,
  output logic [WIDX_W-1:0]          nwords
);
  import opf_pkg::*;

  always_comb begin
    is_end     = (code == K_END);
    legal      = (code <= K_C5);
    is_reg     = (code >= K_RA) && (code <= K_RFAB);
    reg_pair   = (code == K_RAB) || (code == K_RFAB);
    is_ival    = (code == K_IVAL);
    is_ptr     = (code == K_IPTR);
    store_addr = (code == K_IADR);
    adv_pc     = (code >= K_IVAL) && (code <= K_C5);
    nwords     = WIDX_W'(1);
    if (code >= K_C1 && code <= K_C5) nwords = WIDX_W'(code - K_C1 + 4'd1);
  end
endmodule

// File: rtl/opf_result_store.sv
module opf_result_store #(
  parameter int DW         = 16,
  parameter int NSLOT      = 4,
  parameter int SLOT_WORDS = 5,
  localparam int SLOT_W    = $clog2(NSLOT),
  localparam int WIDX_W    = $clog2(SLOT_WORDS),
  localparam int TOT       = NSLOT * SLOT_WORDS,
  localparam int IDX_W     = $clog2(TOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic              wr_pair,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [WIDX_W-1:0] wr_word,
  input  logic [DW-1:0]     wr_hi,
  input  logic [DW-1:0]     wr_lo,
  input  logic [SLOT_W-1:0] rd_slot,
  input  logic [WIDX_W-1:0] rd_word,
  output logic [DW-1:0]     rd_data
);
  logic [DW-1:0] words [TOT];

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    for (genvar w = 0; w < SLOT_WORDS; w++) begin : g_word
      logic hit_hi, hit_lo;
      assign hit_hi = wr_en && (wr_slot == SLOT_W'(s)) && (wr_word == WIDX_W'(w));
      assign hit_lo = wr_en && wr_pair && (wr_slot == SLOT_W'(s)) &&
                      (WIDX_W'(wr_word + WIDX_W'(1)) == WIDX_W'(w));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      words[s*SLOT_WORDS+w] <= '0;
        else if (clr)    words[s*SLOT_WORDS+w] <= '0;
        else if (hit_hi) words[s*SLOT_WORDS+w] <= wr_hi;
        else if (hit_lo) words[s*SLOT_WORDS+w] <= wr_lo;
      end
    end
  end

  logic [IDX_W-1:0] rd_idx;
  always_comb begin
    rd_idx  = IDX_W'(rd_slot) * IDX_W'(SLOT_WORDS) + IDX_W'(rd_word);
    rd_data = '0;
    if (rd_word < WIDX_W'(SLOT_WORDS)) rd_data = words[rd_idx];
  end
endmodule

// File: rtl/opf_seq.sv
module opf_seq #(
  parameter int AW         = 15,
  parameter int DW         = 16,
  parameter int NSLOT      = 4,
  parameter int SLOT_WORDS = 5,
  parameter int HOP_LIMIT  = 3,
  localparam int KW        = opf_pkg::KIND_W,
  localparam int PAT_W     = NSLOT * KW,
  localparam int SLOT_W    = $clog2(NSLOT),
  localparam int WIDX_W    = $clog2(SLOT_WORDS),
  localparam int CNT_W     = $clog2(NSLOT + 1),
  localparam int HOP_W     = $clog2(HOP_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PAT_W-1:0]  pattern,
  input  logic [AW-1:0]     pc_in,
  input  logic [DW-1:0]     a_reg,
  input  logic [DW-1:0]     b_reg,
  input  logic              irq_pending,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [AW-1:0]     mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DW-1:0]     mem_rsp_data,
  output logic              busy,
  output logic              done,
  output logic              abort,
  output logic              error,
  output logic [CNT_W-1:0]  op_count,
  output logic [AW-1:0]     pc_out,
  input  logic [SLOT_W-1:0] rd_slot,
  input  logic [WIDX_W-1:0] rd_word,
  output logic [DW-1:0]     rd_data
);
  import opf_pkg::*;

  opf_state_t        state;
  logic [PAT_W-1:0]  pat;
  logic [SLOT_W-1:0] opi;
  logic [CNT_W-1:0]  cnt;
  logic [AW-1:0]     pc, rd_addr;
  logic              ph_val;
  logic [HOP_W-1:0]  hops;
  logic [WIDX_W-1:0] widx, nw;
  logic              done_q, abort_q, err_q;

  logic [KW-1:0]     code;
  logic              k_end, k_legal, k_reg, k_pair, k_ival, k_ptr, k_sadr, k_adv;
  logic [WIDX_W-1:0] k_nw;
  logic              rsp_ind;
  logic [AW-1:0]     rsp_addr;

  assign code     = pat[KW-1:0];
  assign rsp_ind  = mem_rsp_data[DW-1];
  assign rsp_addr = mem_rsp_data[AW-1:0];

  opf_kind_decode #(.WIDX_W(WIDX_W)) u_dec (
    .code(code), .is_end(k_end), .legal(k_legal), .is_reg(k_reg),
    .reg_pair(k_pair), .is_ival(k_ival), .is_ptr(k_ptr),
    .store_addr(k_sadr), .adv_pc(k_adv), .nwords(k_nw)
  );

  // Slot write port
  logic              wr_en, wr_pair;
  logic [WIDX_W-1:0] wr_word;
  logic [DW-1:0]     wr_hi, wr_lo;
  always_comb begin
    wr_en = 1'b0; wr_pair = 1'b0; wr_word = '0; wr_hi = '0; wr_lo = '0;
    if (state == ST_DECODE && k_legal && k_reg) begin
      wr_en = 1'b1; wr_pair = k_pair; wr_hi = a_reg; wr_lo = b_reg;
    end else if (state == ST_DECODE && k_ptr) begin
      wr_en = 1'b1; wr_hi = {{(DW-AW){1'b0}}, pc};
    end else if (state == ST_RD_WAIT && mem_rsp_valid) begin
      if (ph_val) begin
        wr_en = 1'b1; wr_word = widx; wr_hi = mem_rsp_data;
      end else if (!rsp_ind && k_sadr) begin
        wr_en = 1'b1; wr_hi = {{(DW-AW){1'b0}}, rsp_addr};
      end
    end
  end

  opf_result_store #(.DW(DW), .NSLOT(NSLOT), .SLOT_WORDS(SLOT_WORDS)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(state == ST_IDLE && start),
    .wr_en(wr_en), .wr_pair(wr_pair), .wr_slot(opi), .wr_word(wr_word),
    .wr_hi(wr_hi), .wr_lo(wr_lo),
    .rd_slot(rd_slot), .rd_word(rd_word), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; pat <= '0; opi <= '0; cnt <= '0; pc <= '0;
      rd_addr <= '0; ph_val <= 1'b0; hops <= '0; widx <= '0; nw <= '0;
      done_q <= 1'b0; abort_q <= 1'b0; err_q <= 1'b0;
    end else begin
      done_q <= 1'b0; abort_q <= 1'b0; err_q <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          pat <= pattern; pc <= pc_in; opi <= '0; cnt <= '0;
          state <= ST_DECODE;
        end
        ST_DECODE: begin
          if (k_end) begin
            done_q <= 1'b1; state <= ST_IDLE;
          end else if (!k_legal) begin
            err_q <= 1'b1; state <= ST_IDLE;
          end else if (k_reg || k_ptr) begin
            state <= ST_NEXT;
          end else begin
            rd_addr <= pc; ph_val <= k_ival; hops <= '0;
            widx <= '0; nw <= WIDX_W'(1); state <= ST_RD_REQ;
          end
        end
        ST_RD_REQ: if (mem_req_ready) state <= ST_RD_WAIT;
        ST_RD_WAIT: if (mem_rsp_valid) begin
          if (!ph_val) begin
            if (rsp_ind) begin
              if (hops == HOP_W'(HOP_LIMIT) && irq_pending) begin
                abort_q <= 1'b1; state <= ST_IDLE;
              end else begin
                if (hops != HOP_W'(HOP_LIMIT)) hops <= hops + HOP_W'(1);
                rd_addr <= rsp_addr; state <= ST_RD_REQ;
              end
            end else if (k_sadr) begin
              state <= ST_NEXT;
            end else begin
              rd_addr <= rsp_addr; ph_val <= 1'b1; widx <= '0; nw <= k_nw;
              state <= ST_RD_REQ;
            end
          end else if (widx == WIDX_W'(nw - WIDX_W'(1))) begin
            state <= ST_NEXT;
          end else begin
            widx <= widx + WIDX_W'(1); rd_addr <= rd_addr + AW'(1);
            state <= ST_RD_REQ;
          end
        end
        ST_NEXT: begin
          if (k_adv) pc <= pc + AW'(1);
          cnt <= cnt + CNT_W'(1);
          pat <= pat >> KW;
          if (opi == SLOT_W'(NSLOT - 1)) begin
            done_q <= 1'b1; state <= ST_IDLE;
          end else begin
            opi <= opi + SLOT_W'(1); state <= ST_DECODE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (state == ST_RD_REQ);
  assign mem_req_addr  = rd_addr;
  assign busy          = (state != ST_IDLE);
  assign done          = done_q;
  assign abort         = abort_q;
  assign error         = err_q;
  assign op_count      = cnt;
  assign pc_out        = pc;
endmodule

// File: rtl/opf_seq_checker.sv
module opf_seq_checker #(
  parameter int AW    = 15,
  parameter int NSLOT = 4,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             abort,
  input logic             error,
  input logic             irq_pending,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [AW-1:0]    mem_req_addr,
  input logic [CNT_W-1:0] op_count
);
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid);

  a_r12_single_end: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, abort, error}));

  a_r12_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (done || abort || error) |-> !busy);

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_abort_irq: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> $past(irq_pending));

  a_r10_count_max: assert property (@(posedge clk) disable iff (!rst_n)
    op_count <= CNT_W'(NSLOT));
endmodule

bind opf_seq opf_seq_checker #(.AW(AW), .NSLOT(NSLOT), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .abort(abort),
  .error(error), .irq_pending(irq_pending), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
  .op_count(op_count)
);

// File: tb/opf_seq_bench.sv
module opf_seq_bench;
  logic        clk, rst_n, start, irq_pending;
  logic [15:0] pattern, a_reg, b_reg, mem_rsp_data, rd_data;
  logic [14:0] pc_in, mem_req_addr, pc_out;
  logic        mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic        busy, done, abort, error;
  logic [2:0]  op_count, rd_word;
  logic [1:0]  rd_slot;

  opf_seq u_opf_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .pattern(pattern), .pc_in(pc_in),
    .a_reg(a_reg), .b_reg(b_reg), .irq_pending(irq_pending),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .busy(busy), .done(done), .abort(abort),
    .error(error), .op_count(op_count), .pc_out(pc_out),
    .rd_slot(rd_slot), .rd_word(rd_word), .rd_data(rd_data)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [15:0] mem [int];
  bit stall = 0;
  int hs_count = 0, hold_viol = 0;
  bit got_done, got_abort, got_error, got_busy;

  initial begin clk = 0; forever #5 clk = ~clk; end

  // Memory responder: all decisions made at the falling edge
  initial begin
    bit pend = 0, prev_wait = 0;
    logic [14:0] paddr = '0, prev_addr = '0;
    int cyc = 0;
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (prev_wait && (!mem_req_valid || mem_req_addr != prev_addr)) hold_viol++;
      mem_rsp_valid = 0;
      if (pend) begin
        mem_rsp_valid = 1;
        mem_rsp_data = mem.exists(int'(paddr)) ? mem[int'(paddr)] : 16'h0000;
        pend = 0;
      end
      mem_req_ready = stall ? (cyc % 3 == 0) : 1'b1;
      if (mem_req_valid && mem_req_ready) begin
        pend = 1; paddr = mem_req_addr; hs_count++;
      end
      prev_wait = mem_req_valid && !mem_req_ready;
      prev_addr = mem_req_addr;
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic run(input logic [15:0] pat, input logic [14:0] pc, input logic irq);
    @(negedge clk);
    pattern = pat; pc_in = pc; irq_pending = irq; start = 1;
    @(negedge clk);
    start = 0;
    got_done = 0; got_abort = 0; got_error = 0; got_busy = 1;
    for (int i = 0; i < 3000; i++) begin
      if (done || abort || error) begin
        got_done = done; got_abort = abort; got_error = error; got_busy = busy;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic slot(input int s, input int w, output logic [15:0] v);
    rd_slot = 2'(s); rd_word = 3'(w); #1; v = rd_data;
  endtask

  task automatic chk_slot(input string req, input int s, input int w, input logic [15:0] exp);
    logic [15:0] v;
    slot(s, w, v);
    chk(req, $sformatf("slot%0d word%0d", s, w), 32'(v), 32'(exp));
  endtask

  task automatic t_reset();
    chk("R12", "busy after reset", 32'(busy), 0);
    chk("R12", "done after reset", 32'(done), 0);
    chk("R11", "req idle after reset", 32'(mem_req_valid), 0);
    chk("R1", "count after reset", 32'(op_count), 0);
  endtask

  task automatic t_regs();
    int h0;
    a_reg = 16'hA5A5; b_reg = 16'h0F0F; mem.delete(); h0 = hs_count;
    run(16'h0321, 15'h0040, 0);
    chk("R12", "done", 32'(got_done), 1);
    chk("R12", "busy at end", 32'(got_busy), 0);
    chk("R1", "count", 32'(op_count), 3);
    chk_slot("R2", 0, 0, 16'hA5A5);
    chk_slot("R2", 0, 1, 16'h0000);
    chk_slot("R2", 1, 0, 16'hA5A5);
    chk_slot("R2", 1, 1, 16'h0F0F);
    chk_slot("R2", 2, 1, 16'h0F0F);
    chk("R2", "no memory reads", 32'(hs_count - h0), 0);
    chk("R6", "pc unchanged", 32'(pc_out), 32'h0040);
  endtask

  task automatic t_inline();
    mem.delete();
    mem[32'h100] = 16'h1234; mem[32'h102] = 16'h0200;
    run(16'h0654, 15'h0100, 0);
    chk("R1", "done", 32'(got_done), 1);
    chk_slot("R3", 0, 0, 16'h1234);
    chk_slot("R3", 1, 0, 16'h0101);
    chk_slot("R3", 2, 0, 16'h0200);
    chk("R6", "pc advanced", 32'(pc_out), 32'h0103);
    chk("R1", "count", 32'(op_count), 3);
  endtask

  task automatic t_consts_stall();
    mem.delete(); stall = 1; hold_viol = 0;
    mem[32'h300] = 16'h0400; mem[32'h301] = 16'h0410;
    mem[32'h302] = 16'h0420; mem[32'h303] = 16'h0430;
    mem[32'h400] = 16'h1111;
    mem[32'h410] = 16'h2001; mem[32'h411] = 16'h2002;
    for (int i = 0; i < 3; i++) mem[32'h420 + i] = 16'h3001 + 16'(i);
    for (int i = 0; i < 4; i++) mem[32'h430 + i] = 16'h4001 + 16'(i);
    run(16'hA987, 15'h0300, 0);
    stall = 0;
    chk("R10", "done without end code", 32'(got_done), 1);
    chk("R10", "count of four", 32'(op_count), 4);
    chk_slot("R4", 0, 0, 16'h1111);
    chk_slot("R4", 1, 0, 16'h2001);
    chk_slot("R4", 1, 1, 16'h2002);
    chk_slot("R4", 2, 2, 16'h3003);
    chk_slot("R4", 3, 0, 16'h4001);
    chk_slot("R4", 3, 3, 16'h4004);
    chk("R6", "pc after four", 32'(pc_out), 32'h0304);
    chk("R11", "request held under back-pressure", 32'(hold_viol), 0);
  endtask

  task automatic t_wrap();
    mem.delete();
    mem[32'h10] = 16'h7FFE;
    mem[32'h7FFE] = 16'h5001; mem[32'h7FFF] = 16'h5002;
    mem[32'h0] = 16'h5003; mem[32'h1] = 16'h5004; mem[32'h2] = 16'h5005;
    run(16'h000B, 15'h0010, 0);
    chk_slot("R5", 0, 0, 16'h5001);
    chk_slot("R5", 0, 1, 16'h5002);
    chk_slot("R5", 0, 2, 16'h5003);
    chk_slot("R5", 0, 4, 16'h5005);
    chk("R1", "count", 32'(op_count), 1);
    mem.delete(); mem[32'h7FFF] = 16'hBEEF;
    run(16'h0004, 15'h7FFF, 0);
    chk_slot("R3", 0, 0, 16'hBEEF);
    chk("R5", "pc wraps", 32'(pc_out), 32'h0000);
  endtask

  task automatic t_chain();
    mem.delete();
    mem[32'h20] = 16'h8030; mem[32'h30] = 16'h8040; mem[32'h40] = 16'h0050;
    mem[32'h50] = 16'hCAFE; mem[32'h51] = 16'hF00D;
    run(16'h0008, 15'h0020, 1);
    chk("R7", "done", 32'(got_done), 1);
    chk_slot("R7", 0, 0, 16'hCAFE);
    chk_slot("R7", 0, 1, 16'hF00D);
    chk("R6", "pc", 32'(pc_out), 32'h0021);
  endtask

  task automatic t_abort();
    mem.delete();
    mem[32'h60] = 16'h8070; mem[32'h70] = 16'h8071; mem[32'h71] = 16'h8072;
    mem[32'h72] = 16'h8073; mem[32'h73] = 16'h0080; mem[32'h80] = 16'h7777;
    a_reg = 16'h0042;
    run(16'h0071, 15'h0060, 1);
    chk("R8", "abort on fourth level", 32'(got_abort), 1);
    chk("R8", "no done on abort", 32'(got_done), 0);
    chk("R8", "count at abort", 32'(op_count), 1);
    run(16'h0071, 15'h0060, 0);
    chk("R8", "no irq completes", 32'(got_done), 1);
    chk_slot("R8", 1, 0, 16'h7777);
    mem[32'h72] = 16'h0080;
    run(16'h0007, 15'h0060, 1);
    chk("R8", "three levels with irq", 32'(got_done), 1);
    chk("R8", "three levels no abort", 32'(got_abort), 0);
    chk_slot("R8", 0, 0, 16'h7777);
  endtask

  task automatic t_illegal();
    mem.delete(); mem[32'h90] = 16'h0001;
    run(16'h0D41, 15'h0090, 0);
    chk("R9", "error", 32'(got_error), 1);
    chk("R9", "no done", 32'(got_done), 0);
    chk("R9", "count before bad code", 32'(op_count), 2);
  endtask

  task automatic t_null();
    int h0;
    h0 = hs_count;
    run(16'h0000, 15'h0123, 0);
    chk("R1", "immediate done", 32'(got_done), 1);
    chk("R1", "zero count", 32'(op_count), 0);
    chk("R1", "no reads", 32'(hs_count - h0), 0);
  endtask

  initial begin
    rst_n = 0; start = 0; pattern = '0; pc_in = '0; a_reg = '0; b_reg = '0;
    irq_pending = 0; rd_slot = '0; rd_word = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_inline();
    t_consts_stall();
    t_wrap();
    t_chain();
    t_abort();
    t_illegal();
    t_null();
    finished = 1;
    summary();
    $finish;
  end
endmodule